// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block makes every hazard decision for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the decode-stage instruction class and source registers, and at what the execute, memory and writeback stages hold. From that it drives three kinds of control:

- the operand bypass selects for the instruction in execute;
- a stall that freezes the PC and the fetch/decode register and sends a bubble into execute;
- the kill and PC-source controls for jumps and for taken branches.

The register file, ALU, memories and branch comparator sit outside the block. The execute stage reports a resolved redirect through `ex_taken_i`.

Parameter `BYPASS_EN` picks between two variants:

- **Fully bypassed (default).** The only stall is a load in execute whose result the decode instruction needs.
- **Interlock only.** There is no forwarding. Decode stalls on any pending writer of one of its sources.

The logic is combinational. The clock and reset are used only by the embedded checks.

Instruction class encoding on `*_op_i`:

| Code | Class |
|---|---|
| 0 | register ALU |
| 1 | immediate ALU |
| 2 | load |
| 3 | store |
| 4 | conditional branch |
| 5 | JAL |
| 6 | JALR |
| 7 | other (reads and writes nothing) |

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Source 1 is treated as read for codes 0, 1, 2, 3, 4 and 6. Source 2 is treated as read only for codes 0, 3 and 4. A source that is not read never causes a stall or a forward.
- R2: An execute-stage instruction is a register writer for codes 0, 1, 2, 5 and 6. Codes 3, 4 and 7 never write. The memory and writeback stages state their write through `mem_we_i` and `wb_we_i`.
- R3: With bypassing, an execute operand select is 2'b01 when the valid memory-stage writer's destination equals that operand's source. It is 2'b10 when the valid writeback-stage writer's destination matches instead. When both match, the memory stage wins. Otherwise the select is 2'b00.
- R4: Register 0 is never forwarded and never causes a stall.
- R5: With bypassing, `stall_o` rises only when a valid load in execute has a nonzero destination equal to a source that the decode instruction reads.
- R6: Without bypassing, `stall_o` rises when a read decode source equals the nonzero destination of any valid writer in execute, memory or writeback. Both forward selects stay 2'b00.
- R7: While `stall_o` is high, `ex_bubble_o` is high, `kill_if_o` is low and `pc_sel_o` is 0 (hold).
- R8: A valid JAL in decode sets `kill_if_o` and `pc_sel_o`=1. It does not set `stall_o` or `ex_bubble_o`.
- R9: A valid code 4 or code 6 in execute with `ex_taken_i` high sets `kill_if_o`, `ex_bubble_o` and `pc_sel_o`=2. It suppresses any stall and any decode jump.
- R10: An instruction whose valid bit is 0 produces no stall, forward, jump or kill. This holds in whichever stage it sits.
- R11: `ex_taken_i` has no effect unless the execute stage holds a valid code 4 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| dec_valid_i | input | 1 | Decode slot holds a real instruction |
| dec_op_i | input | 3 | Decode instruction class |
| dec_rs1_i | input | REG_W | Decode source 1 |
| dec_rs2_i | input | REG_W | Decode source 2 |
| ex_valid_i | input | 1 | Execute slot holds a real instruction |
| ex_op_i | input | 3 | Execute instruction class |
| ex_rs1_i | input | REG_W | Execute source 1 |
| ex_rs2_i | input | REG_W | Execute source 2 |
| ex_rd_i | input | REG_W | Execute destination |
| ex_taken_i | input | 1 | Execute resolved a taken branch or JALR |
| mem_valid_i | input | 1 | Memory slot holds a real instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_rd_i | input | REG_W | Memory-stage destination |
| wb_valid_i | input | 1 | Writeback slot holds a real instruction |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| wb_rd_i | input | REG_W | Writeback destination |
| fwd_a_o | output | 2 | Operand 1 source select for execute |
| fwd_b_o | output | 2 | Operand 2 source select for execute |
| stall_o | output | 1 | Hold PC and fetch/decode register |
| ex_bubble_o | output | 1 | Load a bubble into execute instead of decode's instruction |
| kill_if_o | output | 1 | Replace the fetched instruction with a bubble |
| pc_sel_o | output | 2 | Next PC: 0 sequential/hold, 1 jump target, 2 execute redirect |

## Verification
The checks assume a well-formed pipeline picture. `ex_taken_i` is meaningful only for a branch or JALR in execute, and the datapath obeys `stall_o` and the kill controls in the same cycle. Beyond that, any combination of stage contents is legal, so the properties hold for arbitrary classes, registers and valid bits. The stimulus draws register numbers from a small pool so that source and destination matches happen often. It draws the taken flag freely on every class, which exercises R11 as well. Directed vectors add register 0, double matches and a redirect colliding with a stall or a jump.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;

  typedef enum logic [2:0] {
    OP_ALU_R  = 3'd0,
    OP_ALU_I  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_BRANCH = 3'd4,
    OP_JAL    = 3'd5,
    OP_JALR   = 3'd6,
    OP_OTHER  = 3'd7
  } op_e;

  localparam logic [1:0] FWD_RF  = 2'b00;
  localparam logic [1:0] FWD_MEM = 2'b01;
  localparam logic [1:0] FWD_WB  = 2'b10;

  localparam logic [1:0] PC_SEQ   = 2'd0;
  localparam logic [1:0] PC_JUMP  = 2'd1;
  localparam logic [1:0] PC_REDIR = 2'd2;

  function automatic logic op_reads_a(op_e op);
    return op inside {OP_ALU_R, OP_ALU_I, OP_LOAD, OP_STORE, OP_BRANCH, OP_JALR};
  endfunction

  function automatic logic op_reads_b(op_e op);
    return op inside {OP_ALU_R, OP_STORE, OP_BRANCH};
  endfunction

  function automatic logic op_writes(op_e op);
    return op inside {OP_ALU_R, OP_ALU_I, OP_LOAD, OP_JAL, OP_JALR};
  endfunction

endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import pipe_hz_pkg::*;
#(
  parameter int unsigned REG_W     = 5,
  parameter bit          BYPASS_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] rs_i,
  input  logic             mem_valid_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             wb_valid_i,
  input  logic             wb_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  output logic [1:0]       sel_o
);

  generate
    if (BYPASS_EN) begin : g_byp
      logic mem_hit, wb_hit;
      assign mem_hit = rd_en_i && mem_valid_i && mem_we_i &&
                       (mem_rd_i != '0) && (mem_rd_i == rs_i);
      assign wb_hit  = rd_en_i && wb_valid_i && wb_we_i &&
                       (wb_rd_i != '0) && (wb_rd_i == rs_i);

      always_comb begin
        sel_o = FWD_RF;
        if (mem_hit)     sel_o = FWD_MEM;
        else if (wb_hit) sel_o = FWD_WB;
      end

      AST_FWD_NOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o != FWD_RF) |-> (rs_i != '0 && rd_en_i)); // R4
      AST_FWD_YOUNGER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o == FWD_WB) |-> !(mem_valid_i && mem_we_i && mem_rd_i == rs_i)); // R3
    end else begin : g_noby
      logic unused;
      assign unused = ^{rd_en_i, rs_i, mem_valid_i, mem_we_i, mem_rd_i,
                        wb_valid_i, wb_we_i, wb_rd_i};
      assign sel_o  = FWD_RF;
    end
  endgenerate

endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import pipe_hz_pkg::*;
#(
  parameter int unsigned REG_W     = 5,
  parameter bit          BYPASS_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_a_i,
  input  logic             rd_b_i,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic             ex_valid_i,
  input  op_e              ex_op_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             mem_valid_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             wb_valid_i,
  input  logic             wb_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  output logic             stall_o
);

  localparam int unsigned N_PROD = 3;

  logic [N_PROD-1:0] prod_en;
  logic [N_PROD-1:0] prod_hit;
  logic [REG_W-1:0]  prod_rd [N_PROD];

  // with bypassing only a load in execute is too late to forward
  assign prod_en[0] = ex_valid_i && (BYPASS_EN ? (ex_op_i == OP_LOAD) : op_writes(ex_op_i));
  assign prod_en[1] = !BYPASS_EN && mem_valid_i && mem_we_i;
  assign prod_en[2] = !BYPASS_EN && wb_valid_i && wb_we_i;
  assign prod_rd[0] = ex_rd_i;
  assign prod_rd[1] = mem_rd_i;
  assign prod_rd[2] = wb_rd_i;

  for (genvar g = 0; g < N_PROD; g++) begin : g_prod
    assign prod_hit[g] = prod_en[g] && (prod_rd[g] != '0) &&
                         ((rd_a_i && rs1_i == prod_rd[g]) ||
                          (rd_b_i && rs2_i == prod_rd[g]));
  end

  assign stall_o = |prod_hit;

  AST_STALL_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (rd_a_i || rd_b_i)); // R10

  generate
    if (BYPASS_EN) begin : g_chk_byp
      AST_STALL_ONLY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> (ex_valid_i && ex_op_i == OP_LOAD && ex_rd_i != '0)); // R5
    end
  endgenerate

endmodule

// File: rtl/hz_flow_unit.sv
module hz_flow_unit
  import pipe_hz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dec_valid_i,
  input  op_e        dec_op_i,
  input  logic       ex_valid_i,
  input  op_e        ex_op_i,
  input  logic       ex_taken_i,
  input  logic       raw_stall_i,
  output logic       stall_o,
  output logic       ex_bubble_o,
  output logic       kill_if_o,
  output logic [1:0] pc_sel_o
);

  logic redirect, jump;

  assign redirect = ex_valid_i && ex_taken_i && (ex_op_i inside {OP_BRANCH, OP_JALR});
  // a redirect kills decode, so its jump or stall request is void
  assign jump     = dec_valid_i && (dec_op_i == OP_JAL) && !redirect;

  assign stall_o     = raw_stall_i && !redirect;
  assign ex_bubble_o = stall_o || redirect;
  assign kill_if_o   = redirect || jump;

  always_comb begin
    pc_sel_o = PC_SEQ;
    if (redirect)  pc_sel_o = PC_REDIR;
    else if (jump) pc_sel_o = PC_JUMP;
  end

  AST_REDIRECT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && ex_taken_i && ex_op_i == OP_BRANCH) |-> (!stall_o && kill_if_o && ex_bubble_o)); // R9
  AST_STALL_HOLDS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (pc_sel_o == PC_SEQ && ex_bubble_o && !kill_if_o)); // R7
  AST_JUMP_NO_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_sel_o == PC_JUMP) |-> (dec_valid_i && kill_if_o && !ex_bubble_o)); // R8
  AST_TAKEN_NEEDS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_sel_o == PC_REDIR) |-> (ex_valid_i && ex_op_i != OP_LOAD && ex_op_i != OP_ALU_R)); // R11

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hz_pkg::*;
#(
  parameter int unsigned REG_W     = 5,
  parameter bit          BYPASS_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [2:0]       dec_op_i,
  input  logic [REG_W-1:0] dec_rs1_i,
  input  logic [REG_W-1:0] dec_rs2_i,
  input  logic             ex_valid_i,
  input  logic [2:0]       ex_op_i,
  input  logic [REG_W-1:0] ex_rs1_i,
  input  logic [REG_W-1:0] ex_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_taken_i,
  input  logic             mem_valid_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             wb_valid_i,
  input  logic             wb_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             stall_o,
  output logic             ex_bubble_o,
  output logic             kill_if_o,
  output logic [1:0]       pc_sel_o
);

  localparam int unsigned N_OPND = 2;

  op_e dec_op, ex_op;
  logic dec_rd_a, dec_rd_b, raw_stall;
  logic [N_OPND-1:0] ex_rd_en;
  logic [REG_W-1:0]  ex_rs [N_OPND];
  logic [1:0]        fwd   [N_OPND];

  assign dec_op   = op_e'(dec_op_i);
  assign ex_op    = op_e'(ex_op_i);
  assign dec_rd_a = dec_valid_i && op_reads_a(dec_op);
  assign dec_rd_b = dec_valid_i && op_reads_b(dec_op);

  assign ex_rd_en[0] = ex_valid_i && op_reads_a(ex_op);
  assign ex_rd_en[1] = ex_valid_i && op_reads_b(ex_op);
  assign ex_rs[0]    = ex_rs1_i;
  assign ex_rs[1]    = ex_rs2_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hz_fwd_unit #(.REG_W(REG_W), .BYPASS_EN(BYPASS_EN)) u_fwd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_en_i    (ex_rd_en[g]),
      .rs_i       (ex_rs[g]),
      .mem_valid_i(mem_valid_i),
      .mem_we_i   (mem_we_i),
      .mem_rd_i   (mem_rd_i),
      .wb_valid_i (wb_valid_i),
      .wb_we_i    (wb_we_i),
      .wb_rd_i    (wb_rd_i),
      .sel_o      (fwd[g])
    );
  end

  assign fwd_a_o = fwd[0];
  assign fwd_b_o = fwd[1];

  hz_stall_unit #(.REG_W(REG_W), .BYPASS_EN(BYPASS_EN)) u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_i     (dec_rd_a),
    .rd_b_i     (dec_rd_b),
    .rs1_i      (dec_rs1_i),
    .rs2_i      (dec_rs2_i),
    .ex_valid_i (ex_valid_i),
    .ex_op_i    (ex_op),
    .ex_rd_i    (ex_rd_i),
    .mem_valid_i(mem_valid_i),
    .mem_we_i   (mem_we_i),
    .mem_rd_i   (mem_rd_i),
    .wb_valid_i (wb_valid_i),
    .wb_we_i    (wb_we_i),
    .wb_rd_i    (wb_rd_i),
    .stall_o    (raw_stall)
  );

  hz_flow_unit u_flow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dec_valid_i(dec_valid_i),
    .dec_op_i   (dec_op),
    .ex_valid_i (ex_valid_i),
    .ex_op_i    (ex_op),
    .ex_taken_i (ex_taken_i),
    .raw_stall_i(raw_stall),
    .stall_o    (stall_o),
    .ex_bubble_o(ex_bubble_o),
    .kill_if_o  (kill_if_o),
    .pc_sel_o   (pc_sel_o)
  );

  AST_INVALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_valid_i && !ex_valid_i) |-> (!stall_o && !kill_if_o && fwd_a_o == 2'b00 && fwd_b_o == 2'b00)); // R10

endmodule

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;

  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          dv, exv, exk, mv, mwe, wv, wwe;
  logic [2:0]    dop, exop;
  logic [RW-1:0] rs1, rs2, exs1, exs2, exrd, mrd, wrd;

  logic [1:0] fa_b, fb_b, pc_b, fa_i, fb_i, pc_i;
  logic       st_b, bu_b, ki_b, st_i, bu_i, ki_i;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  pipe_hazard_ctrl #(.REG_W(RW), .BYPASS_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_valid_i(dv), .dec_op_i(dop), .dec_rs1_i(rs1), .dec_rs2_i(rs2),
    .ex_valid_i(exv), .ex_op_i(exop), .ex_rs1_i(exs1), .ex_rs2_i(exs2),
    .ex_rd_i(exrd), .ex_taken_i(exk),
    .mem_valid_i(mv), .mem_we_i(mwe), .mem_rd_i(mrd),
    .wb_valid_i(wv), .wb_we_i(wwe), .wb_rd_i(wrd),
    .fwd_a_o(fa_b), .fwd_b_o(fb_b), .stall_o(st_b), .ex_bubble_o(bu_b),
    .kill_if_o(ki_b), .pc_sel_o(pc_b)
  );

  pipe_hazard_ctrl #(.REG_W(RW), .BYPASS_EN(1'b0)) dut_il_i (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_valid_i(dv), .dec_op_i(dop), .dec_rs1_i(rs1), .dec_rs2_i(rs2),
    .ex_valid_i(exv), .ex_op_i(exop), .ex_rs1_i(exs1), .ex_rs2_i(exs2),
    .ex_rd_i(exrd), .ex_taken_i(exk),
    .mem_valid_i(mv), .mem_we_i(mwe), .mem_rd_i(mrd),
    .wb_valid_i(wv), .wb_we_i(wwe), .wb_rd_i(wrd),
    .fwd_a_o(fa_i), .fwd_b_o(fb_i), .stall_o(st_i), .ex_bubble_o(bu_i),
    .kill_if_o(ki_i), .pc_sel_o(pc_i)
  );

  // class tables from R1/R2
  function automatic bit rd1(logic [2:0] op);
    return op inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
  endfunction
  function automatic bit rd2(logic [2:0] op);
    return op inside {3'd0, 3'd3, 3'd4};
  endfunction
  function automatic bit wrs(logic [2:0] op);
    return op inside {3'd0, 3'd1, 3'd2, 3'd5, 3'd6};
  endfunction

  function automatic logic [1:0] exp_fwd(bit byp, bit en, logic [RW-1:0] rs);
    if (!byp || !en) return 2'b00;
    if (mv && mwe && mrd != 0 && mrd == rs) return 2'b01;
    if (wv && wwe && wrd != 0 && wrd == rs) return 2'b10;
    return 2'b00;
  endfunction

  function automatic bit hit(bit en, logic [RW-1:0] rd);
    return en && rd != 0 && ((dv && rd1(dop) && rs1 == rd) || (dv && rd2(dop) && rs2 == rd));
  endfunction

  // {fa, fb, stall, bubble, kill, pc}
  function automatic logic [8:0] expect_out(bit byp);
    bit redir, jump, raw, st;
    logic [1:0] pc;
    redir = exv && exk && (exop == 3'd4 || exop == 3'd6);
    jump  = dv && dop == 3'd5 && !redir;
    if (byp) raw = hit(exv && exop == 3'd2, exrd);
    else     raw = hit(exv && wrs(exop), exrd) || hit(mv && mwe, mrd) || hit(wv && wwe, wrd);
    st = raw && !redir;
    pc = redir ? 2'd2 : (jump ? 2'd1 : 2'd0);
    return {exp_fwd(byp, exv && rd1(exop), exs1), exp_fwd(byp, exv && rd2(exop), exs2),
            st, st || redir, redir || jump, pc};
  endfunction

  task automatic chk(string req, logic [8:0] got, logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b (dv=%0d dop=%0d rs1=%0d rs2=%0d exv=%0d exop=%0d exrd=%0d tk=%0d mv=%0d mrd=%0d wv=%0d wrd=%0d)",
               req, got, exp, dv, dop, rs1, rs2, exv, exop, exrd, exk, mv, mrd, wv, wrd);
    end
  endtask

  task automatic check_both(string req);
    #4;
    chk({req, "/byp"}, {fa_b, fb_b, st_b, bu_b, ki_b, pc_b}, expect_out(1'b1));
    chk({req, "/il"},  {fa_i, fb_i, st_i, bu_i, ki_i, pc_i}, expect_out(1'b0));
    @(posedge clk); #1;
  endtask

  task automatic clear();
    {dv, exv, exk, mv, mwe, wv, wwe} = '0;
    {dop, exop} = '0;
    {rs1, rs2, exs1, exs2, exrd, mrd, wrd} = '0;
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    #4;
    chk("R10 reset", {fa_b, fb_b, st_b, bu_b, ki_b, pc_b}, 9'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5/R1: load-use on rs2 of a register ALU op
    clear(); dv = 1; dop = 3'd0; rs1 = 7; rs2 = 9; exv = 1; exop = 3'd2; exrd = 9;
    check_both("R5 load-use");
    // R1: JAL reads nothing, so no stall even though rs1 matches
    dop = 3'd5; rs1 = 9;
    check_both("R1 jal no read");
    // R1: immediate ALU ignores rs2
    dop = 3'd1; rs1 = 3; rs2 = 9;
    check_both("R1 imm rs2 unread");
    // R4: register 0 load dest
    dop = 3'd0; rs1 = 0; exrd = 0;
    check_both("R4 zero");
    // R3: both stages match, memory wins
    clear(); exv = 1; exop = 3'd0; exs1 = 4; exs2 = 4; mv = 1; mwe = 1; mrd = 4; wv = 1; wwe = 1; wrd = 4;
    check_both("R3 priority");
    mrd = 6;
    check_both("R3 wb only");
    mwe = 0; mrd = 4;
    check_both("R2 mem no write");
    // R2: store in execute is not a writer (interlock)
    clear(); dv = 1; dop = 3'd0; rs1 = 5; exv = 1; exop = 3'd3; exrd = 5;
    check_both("R2 store");
    exop = 3'd5;
    check_both("R6 jal writer");
    // R9: redirect overrides stall
    clear(); dv = 1; dop = 3'd0; rs1 = 2; exv = 1; exop = 3'd4; exrd = 2; exk = 1; mv = 1; mwe = 1; mrd = 2;
    check_both("R9 redirect over stall");
    dop = 3'd5;
    check_both("R9 redirect over jump");
    exop = 3'd6;
    check_both("R9 jalr");
    // R11: taken flag on non-control
    exop = 3'd1;
    check_both("R11 taken ignored");
    // R10: invalid everywhere with matches present
    clear(); dop = 3'd0; rs1 = 3; exop = 3'd2; exrd = 3; exk = 1; exs1 = 3; mwe = 1; mrd = 3; wwe = 1; wrd = 3;
    exop = 3'd4;
    check_both("R10 invalid");
    // R7: stall behaviour
    clear(); dv = 1; dop = 3'd3; rs1 = 1; rs2 = 8; exv = 1; exop = 3'd2; exrd = 8;
    check_both("R7 stall hold");
    // R8
    clear(); dv = 1; dop = 3'd5;
    check_both("R8 jump");

    for (int i = 0; i < 3000; i++) begin
      dv = ($urandom % 5) != 0; exv = ($urandom % 5) != 0;
      mv = ($urandom % 5) != 0; wv = ($urandom % 5) != 0;
      mwe = $urandom; wwe = $urandom; exk = $urandom;
      dop = 3'($urandom); exop = 3'($urandom);
      rs1 = RW'($urandom % 4); rs2 = RW'($urandom % 4);
      exs1 = RW'($urandom % 4); exs2 = RW'($urandom % 4);
      exrd = RW'($urandom % 4); mrd = RW'($urandom % 4); wrd = RW'($urandom % 4);
      check_both("R3 R5 R6 R9 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule